// File: doc/BRIEF.md
# Configurable Parallel I/O Port Bank

This block gives a host microcontroller four parallel I/O ports whose pins are set up one by one. For each pin the host writes three settings. The first is a mode select, which chooses between host-driven data and a latched address bit. The second is a direction bit. The third is a drive-type bit, which chooses push-pull or open-drain. An external output-enable product term can force any pin of ports A, B and C to drive, whatever its direction bit says. The block drives per-pin output value, output-enable and open-drain flag signals towards the pads. It also lets the host read back the state of the pins.

Ports A, B and C are eight pins wide and port D is three pins wide. Only ports A and B have a mode register, and port D ignores the product term. The host reaches the registers over a small synchronous bus with chip-select, write-strobe and read-strobe inputs. Writes take effect on the clock edge and reads return data combinationally.

Top module: `io_port_bank`

## Requirements
- R1: After reset every register is 00h, so every pin has output-enable 0 and open-drain flag 0, and every register reads 00h.
- R2: Register address = port base + offset. The port bases are A 0x00, B 0x08, C 0x10 and D 0x18. The offsets are 0 pin state (read-only), 1 output data, 2 mode, 3 direction, 4 drive type. A write takes effect on the rising clock edge only with cs_i=1 and wr_i=1. A read returns data in the same cycle only with cs_i=1 and rd_i=1, and rdata_o is 0 at all other times.
- R3: Register bit i controls pin i of its port. With mode 0, direction 1 and drive type 0, the pin has output-enable 1 and drives bit i of the output data register. With direction 0 and product term 0, output-enable is 0.
- R4: On ports A, B and C, a product-term bit of 1 makes the pin drive even when its direction bit is 0.
- R5: Port D has three pins. Bits 7..3 of its registers read 0 and writes to them are ignored, and no product term acts on its pins.
- R6: On ports A and B, a mode bit of 1 makes the pin drive the matching bit of the latched address (A from addr_lat_i[7:0], B from addr_lat_i[15:8]) in place of the output data bit. On ports C and D the mode register reads 0, writes to it are ignored, and the pins keep driving the output data bit.
- R7: A drive-type bit of 1 sets the pin's open-drain flag. In that mode the pin drives low, with output-enable 1 and output 0, only when its data is 0, and it releases the pin (output-enable 0) when its data is 1.
- R8: Offset 0 of each port returns the pin input states, with bit i taken from pin i of that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register block select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| addr_lat_i | input | 16 | Latched address (A low byte, B high byte) |
| pt_oe_i | input | 24 | Product-term output enables for A, B, C (8 bits each, in that order) |
| pin_in_i | input | 27 | Pin input states (A 7:0, B 15:8, C 23:16, D 26:24) |
| pin_out_o | output | 27 | Pin output values |
| pin_oe_o | output | 27 | Pin output enables |
| pin_od_o | output | 27 | Open-drain flags |

## Verification
The direction test writes a mixed pattern of set and cleared bits. This shows that each bit controls the pin of the same index, and that the pin drives the data bit rather than some neighbouring bit. The product-term test uses a port whose direction bits are all 0 and sets only the end bits of the product term, so any drive on those pins can only come from the product term. The mode test sets the upper half of port B to address mode and leaves the lower half in data mode. It uses an address byte and a data byte that differ, which shows which source each half of the port follows. The open-drain test uses a data pattern that is half 0 and half 1, which separates the pins that pull low from the pins that are released.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int NPORT  = 4;
  localparam int DW     = 8;
  localparam int AW     = 8;
  localparam int STRIDE = 8;

  localparam logic [2:0] OFS_PIN  = 3'd0;
  localparam logic [2:0] OFS_DOUT = 3'd1;
  localparam logic [2:0] OFS_MODE = 3'd2;
  localparam logic [2:0] OFS_DIR  = 3'd3;
  localparam logic [2:0] OFS_DRV  = 3'd4;

  function automatic int port_width(input int p);
    return (p == 3) ? 3 : 8;
  endfunction

  function automatic int port_lsb(input int p);
    int s;
    s = 0;
    for (int i = 0; i < p; i++) s += port_width(i);
    return s;
  endfunction

  localparam int TOTAL_PINS = port_lsb(NPORT);
  localparam int NMODE      = 2;  // ports with mode register
  localparam int NPT        = 3;  // ports with product-term enable
endpackage

// File: rtl/io_pin_cell.sv
module io_pin_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic dout_i,
  input  logic addr_i,
  input  logic dir_i,
  input  logic pt_i,
  input  logic drv_i,
  output logic out_o,
  output logic oe_o,
  output logic od_o
);
  logic data;
  logic drive_req;

  assign data      = mode_i ? addr_i : dout_i;
  assign drive_req = dir_i | pt_i;

  always_comb begin
    od_o = drv_i;
    if (drv_i) begin
      out_o = 1'b0;                  // open drain: only pull low
      oe_o  = drive_req & ~data;
    end else begin
      out_o = data;
      oe_o  = drive_req;
    end
  end

  p_od_never_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_o && oe_o) |-> !out_o);

  p_idle_is_input_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_i && !pt_i) |-> !oe_o);
endmodule

// File: rtl/io_port_slice.sv
module io_port_slice
  import io_port_pkg::*;
#(
  parameter int         W        = 8,
  parameter bit         HAS_MODE = 1'b1,
  parameter bit         HAS_PT   = 1'b1,
  parameter logic [7:0] BASE     = 8'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [W-1:0]  addr_lat_i,
  input  logic [W-1:0]  pt_oe_i,
  input  logic [W-1:0]  pin_in_i,
  output logic [W-1:0]  pin_out_o,
  output logic [W-1:0]  pin_oe_o,
  output logic [W-1:0]  pin_od_o
);
  logic       hit;
  logic [2:0] ofs;
  logic [W-1:0] dout_q, mode_q, dir_q, drv_q, pt_eff;

  assign hit = cs_i && (addr_i[AW-1:3] == BASE[AW-1:3]);
  assign ofs = addr_i[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '0;
      drv_q  <= '0;
    end else if (hit && wr_i) begin
      if (ofs == OFS_DOUT) dout_q <= wdata_i;
      if (ofs == OFS_DIR)  dir_q  <= wdata_i;
      if (ofs == OFS_DRV)  drv_q  <= wdata_i;
    end
  end

  if (HAS_MODE) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mode_q <= '0;
      else if (hit && wr_i && ofs == OFS_MODE) mode_q <= wdata_i;
    end
  end else begin : g_no_mode
    assign mode_q = '0;
  end

  assign pt_eff = HAS_PT ? pt_oe_i : '0;

  always_comb begin
    rdata_o = '0;
    if (hit && rd_i) begin
      case (ofs)
        OFS_PIN:  rdata_o[W-1:0] = pin_in_i;
        OFS_DOUT: rdata_o[W-1:0] = dout_q;
        OFS_MODE: rdata_o[W-1:0] = mode_q;
        OFS_DIR:  rdata_o[W-1:0] = dir_q;
        OFS_DRV:  rdata_o[W-1:0] = drv_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    io_pin_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode_q[i]),
      .dout_i (dout_q[i]),
      .addr_i (addr_lat_i[i]),
      .dir_i  (dir_q[i]),
      .pt_i   (pt_eff[i]),
      .drv_i  (drv_q[i]),
      .out_o  (pin_out_o[i]),
      .oe_o   (pin_oe_o[i]),
      .od_o   (pin_od_o[i])
    );
  end

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wr_i && ofs == OFS_DIR) |=> (dir_q == $past(wdata_i)));

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && wr_i) |=> ($stable(dir_q) && $stable(drv_q) && $stable(dout_q)));
endmodule

// File: rtl/io_port_bank.sv
module io_port_bank
  import io_port_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic [NMODE*8-1:0]    addr_lat_i,
  input  logic [NPT*8-1:0]      pt_oe_i,
  input  logic [TOTAL_PINS-1:0] pin_in_i,
  output logic [TOTAL_PINS-1:0] pin_out_o,
  output logic [TOTAL_PINS-1:0] pin_oe_o,
  output logic [TOTAL_PINS-1:0] pin_od_o
);
  logic [DW-1:0] rd_port [NPORT];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam int W   = port_width(g);
    localparam int LSB = port_lsb(g);
    logic [W-1:0] lat, pt;

    if (g < NMODE) begin : g_lat
      assign lat = addr_lat_i[g*8 +: W];
    end else begin : g_nolat
      assign lat = '0;
    end
    if (g < NPT) begin : g_pt
      assign pt = pt_oe_i[g*8 +: W];
    end else begin : g_nopt
      assign pt = '0;
    end

    io_port_slice #(
      .W        (W),
      .HAS_MODE (g < NMODE),
      .HAS_PT   (g < NPT),
      .BASE     (8'(g * STRIDE))
    ) u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cs_i       (cs_i),
      .wr_i       (wr_i),
      .rd_i       (rd_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i[W-1:0]),
      .rdata_o    (rd_port[g]),
      .addr_lat_i (lat),
      .pt_oe_i    (pt),
      .pin_in_i   (pin_in_i[LSB +: W]),
      .pin_out_o  (pin_out_o[LSB +: W]),
      .pin_oe_o   (pin_oe_o[LSB +: W]),
      .pin_od_o   (pin_od_o[LSB +: W])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NPORT; p++) rdata_o |= rd_port[p];
  end

  p_rdata_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> (rdata_o == '0));
endmodule

// File: tb/io_port_bank_tb_top.sv
module io_port_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] addr_lat = '0;
  logic [23:0] pt_oe = '0;
  logic [26:0] pin_in = '0;
  logic [26:0] pin_out, pin_oe, pin_od;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  io_port_bank dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .addr_lat_i(addr_lat),
    .pt_oe_i(pt_oe), .pin_in_i(pin_in), .pin_out_o(pin_out),
    .pin_oe_o(pin_oe), .pin_od_o(pin_od)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    cs = 1'b0; rd = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 oe", 32'(pin_oe), 0);
    chk("R1 od", 32'(pin_od), 0);
    bus_rd(8'h03, d); chk("R1 dir A", 32'(d), 0);
    bus_rd(8'h0A, d); chk("R1 mode B", 32'(d), 0);
  endtask

  task automatic t_dir;
    logic [7:0] d;
    bus_wr(8'h01, 8'hA5);
    bus_wr(8'h03, 8'h0F);
    chk("R3 oe A", 32'(pin_oe[7:0]), 32'h0F);
    chk("R3 out A", 32'(pin_out[3:0]), 32'h5);
    bus_rd(8'h03, d); chk("R2 dir A read", 32'(d), 32'h0F);
    @(negedge clk); rd = 1'b0; cs = 1'b1; addr = 8'h03;
    #1 chk("R2 no rd strobe", 32'(rdata), 0);
    cs = 1'b0;
    bus_wr(8'h03, 8'hFF, 1'b0);
    bus_rd(8'h03, d); chk("R2 write without cs", 32'(d), 32'h0F);
  endtask

  task automatic t_pt;
    bus_wr(8'h11, 8'hFF);
    @(negedge clk); pt_oe[23:16] = 8'h81;
    #1 chk("R4 pt oe C", 32'(pin_oe[23:16]), 32'h81);
    chk("R4 pt out C", 32'(pin_out[23:16] & 8'h81), 32'h81);
    @(negedge clk); pt_oe = '0;
    #1 chk("R4 pt released", 32'(pin_oe[23:16]), 0);
  endtask

  task automatic t_portd;
    logic [7:0] d;
    bus_wr(8'h19, 8'hFF);
    bus_wr(8'h1B, 8'hFA);
    bus_rd(8'h1B, d); chk("R5 dir D upper bits", 32'(d), 32'h02);
    chk("R5 oe D", 32'(pin_oe[26:24]), 32'h2);
    bus_wr(8'h1B, 8'h00);
    @(negedge clk); pt_oe = 24'hFFFFFF;
    #1 chk("R5 D ignores pt", 32'(pin_oe[26:24]), 0);
    @(negedge clk); pt_oe = '0;
  endtask

  task automatic t_mode;
    logic [7:0] d;
    addr_lat = 16'hAB5C;
    bus_wr(8'h09, 8'h00);
    bus_wr(8'h0B, 8'hFF);
    bus_wr(8'h0A, 8'hF0);
    chk("R6 B addr/data mix", 32'(pin_out[15:8]), 32'hA0);
    bus_wr(8'h02, 8'hFF);
    chk("R6 A addr out", 32'(pin_out[3:0]), 32'hC);
    bus_wr(8'h12, 8'hFF);
    bus_rd(8'h12, d); chk("R6 C mode reads 0", 32'(d), 0);
    bus_wr(8'h11, 8'h3C);
    bus_wr(8'h13, 8'hFF);
    chk("R6 C keeps data", 32'(pin_out[23:16]), 32'h3C);
    bus_wr(8'h02, 8'h00);
  endtask

  task automatic t_od;
    bus_wr(8'h03, 8'hFF);
    bus_wr(8'h01, 8'h0F);
    bus_wr(8'h04, 8'hFF);
    chk("R7 od flag", 32'(pin_od[7:0]), 32'hFF);
    chk("R7 od oe", 32'(pin_oe[7:0]), 32'hF0);
    chk("R7 od low", 32'(pin_out[7:0] & pin_oe[7:0]), 0);
    chk("R7 other ports push-pull", 32'(pin_od[26:8]), 0);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    @(negedge clk); pin_in = 27'h5_C3_96_E1 ^ 27'h0;
    bus_rd(8'h00, d); chk("R8 pins A", 32'(d), 32'(pin_in[7:0]));
    bus_rd(8'h08, d); chk("R8 pins B", 32'(d), 32'(pin_in[15:8]));
    bus_rd(8'h10, d); chk("R8 pins C", 32'(d), 32'(pin_in[23:16]));
    bus_rd(8'h18, d); chk("R8 pins D", 32'(d), 32'(pin_in[26:24]));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    @(negedge clk); rst_ni = 1'b1;
    t_reset();
    t_dir();
    t_pt();
    t_portd();
    t_mode();
    t_od();
    t_readback();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule